// File: doc/BRIEF.md
# UART Receive Line Status Unit

This block holds received characters and keeps the receive half of a UART's line status word. Each time the serial receiver finishes a character, it gives a one-cycle strobe with the character and three check results: parity mismatch, bad stop bit and break. The block stores the character and keeps the status bits that software reads: data ready, overrun, parity error, framing error and break.

It has two storage modes. In single-buffer mode one holding register keeps the latest character. Its error flags are sticky until software reads the status word. In queued mode a FIFO stores each character together with its own three error tags. The status word shows only the tags of the character at the FIFO head. A full FIFO refuses a new character and raises overrun instead. A change of mode empties both stores.

All state is registered. The CPU's read strobes for the buffer and the status word act at the next clock edge.

Top module: `uart_rx_line_status`

## Requirements
- R1: While reset is asserted and after it, stat_o, buf_data_o and fifo_full_o are all zero.
- R2: stat_o[0] (data ready) is 1 in the cycle after a character strobe. In queued mode it returns to 0 only after the last stored character is read. In single-buffer mode it returns to 0 after the held character is read.
- R3: In queued mode buf_data_o shows the oldest unread character, and each buffer read removes it. Characters come out in arrival order.
- R4: In single-buffer mode, a strobe while a character is held and no buffer read happens in the same cycle replaces the held character and sets stat_o[1] (overrun). A strobe together with a buffer read sets no overrun.
- R5: In queued mode with DEPTH entries stored (fifo_full_o = 1), a strobe without a same-cycle buffer read sets stat_o[1], and the FIFO contents do not change. A strobe together with a buffer read is accepted.
- R6: A status read clears stat_o[1]. If an overrun event happens in the same cycle, the flag stays set.
- R7: In single-buffer mode, stat_o[2] (parity), stat_o[3] (framing) and stat_o[4] (break) are set by a strobe that carries that error. They stay set through buffer reads and clear on a status read. A same-cycle set wins.
- R8: In queued mode, stat_o[4:2] show the break, framing and parity tags of the head entry only. They are 0 when the FIFO is empty.
- R9: In queued mode, a status read hides the current head's tags until that entry is read. The next head then shows its own tags.
- R10: A change of fifo_mode_i clears all stored characters, stat_o and fifo_full_o at the next edge. The strobe in that cycle is dropped.
- R11: A buffer read with nothing stored changes nothing, and buf_data_o is 0 while nothing is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_mode_i | input | 1 | 1 = queued mode, 0 = single-buffer mode |
| rx_done_i | input | 1 | Character-complete strobe from the receiver |
| rx_char_i | input | 8 | Received character |
| rx_par_bad_i | input | 1 | Parity check failed for this character |
| rx_stop_bad_i | input | 1 | Stop bit was invalid for this character |
| rx_brk_i | input | 1 | Break detected for this character |
| buf_rd_i | input | 1 | CPU read of the receive buffer |
| stat_rd_i | input | 1 | CPU read of the status word |
| buf_data_o | output | 8 | Held or head character, 0 when empty |
| stat_o | output | 5 | {break, framing, parity, overrun, data ready} |
| fifo_full_o | output | 1 | Queued mode and DEPTH entries stored |

## Verification
Every result comes from a register, so each strobe, buffer read or status read shows at the outputs exactly one edge later, with no longer path. The bench drives inputs at the falling edge. A queue-based model takes one step at the rising edge, and all outputs are compared with the model at the next falling edge, so every check lands on the cycle in which the result is due. Directed sequences cover the overrun, same-cycle priority, per-entry tag and mode-flush cases. A long random run with occasional mode changes follows them.

// File: rtl/uart_rx_ls_pkg.sv
package uart_rx_ls_pkg;
  localparam int DATA_W = 8;
  localparam int STAT_W = 5;

  typedef struct packed {
    logic              brk;
    logic              stop_bad;
    logic              par_bad;
    logic [DATA_W-1:0] data;
  } rx_entry_t;
endpackage

// File: rtl/uart_rx_ls_fifo.sv
module uart_rx_ls_fifo
  import uart_rx_ls_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      flush_i,
  input  logic      push_i,
  input  rx_entry_t wdata_i,
  input  logic      pop_i,
  output rx_entry_t head_o,
  output logic      empty_o,
  output logic      full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  rx_entry_t       mem_q [DEPTH];
  logic [AW-1:0]   wr_q, rd_q;
  logic [CW-1:0]   cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign head_o  = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i)  rd_q <= nxt(rd_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || flush_i)
    push_i |-> (!full_o || pop_i));

  // R11
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || flush_i)
    pop_i |-> !empty_o);

  // R2
  push_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !flush_i) |=> !empty_o);
endmodule

// File: rtl/uart_rx_ls_hold.sv
module uart_rx_ls_hold
  import uart_rx_ls_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              load_i,
  input  rx_entry_t         wdata_i,
  input  logic              rd_i,
  input  logic              clr_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic [2:0]        err_o
);
  logic              valid_q;
  logic [DATA_W-1:0] data_q;
  logic [2:0]        err_q, err_set;

  assign err_set = load_i ? {wdata_i.brk, wdata_i.stop_bad, wdata_i.par_bad} : 3'b000;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      err_q   <= '0;
    end else if (flush_i) begin
      valid_q <= 1'b0;
      err_q   <= '0;
    end else begin
      if (load_i) begin
        valid_q <= 1'b1;
        data_q  <= wdata_i.data;
      end else if (rd_i) begin
        valid_q <= 1'b0;
      end
      // set beats clear
      err_q <= err_set | (err_q & ~{3{clr_i}});
    end
  end

  assign valid_o = valid_q;
  assign data_o  = valid_q ? data_q : '0;
  assign err_o   = err_q;

  // R7
  sticky_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !flush_i && wdata_i.par_bad) |=> err_o[0]);

  // R7
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && !clr_i && err_o[1]) |=> err_o[1]);
endmodule

// File: rtl/uart_rx_line_status.sv
module uart_rx_line_status
  import uart_rx_ls_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_mode_i,
  input  logic              rx_done_i,
  input  logic [DATA_W-1:0] rx_char_i,
  input  logic              rx_par_bad_i,
  input  logic              rx_stop_bad_i,
  input  logic              rx_brk_i,
  input  logic              buf_rd_i,
  input  logic              stat_rd_i,
  output logic [DATA_W-1:0] buf_data_o,
  output logic [STAT_W-1:0] stat_o,
  output logic              fifo_full_o
);
  logic              mode_q, flush;
  rx_entry_t         entry, f_head;
  logic              f_push, f_pop, f_empty, f_full;
  logic              h_load, h_rd, h_valid;
  logic [DATA_W-1:0] h_data;
  logic [2:0]        h_err, head_err;
  logic              ovr_q, ovr_set, ack_q;

  assign flush = fifo_mode_i ^ mode_q;
  assign entry = '{brk: rx_brk_i, stop_bad: rx_stop_bad_i, par_bad: rx_par_bad_i, data: rx_char_i};

  assign f_pop  = fifo_mode_i && !flush && buf_rd_i && !f_empty;
  assign f_push = fifo_mode_i && !flush && rx_done_i && (!f_full || f_pop);
  assign h_load = !fifo_mode_i && !flush && rx_done_i;
  assign h_rd   = !fifo_mode_i && !flush && buf_rd_i;

  assign ovr_set = !flush && rx_done_i &&
                   (fifo_mode_i ? (f_full && !f_pop) : (h_valid && !buf_rd_i));

  uart_rx_ls_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .push_i  (f_push),
    .wdata_i (entry),
    .pop_i   (f_pop),
    .head_o  (f_head),
    .empty_o (f_empty),
    .full_o  (f_full)
  );

  uart_rx_ls_hold u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .load_i  (h_load),
    .wdata_i (entry),
    .rd_i    (h_rd),
    .clr_i   (stat_rd_i),
    .valid_o (h_valid),
    .data_o  (h_data),
    .err_o   (h_err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      ovr_q  <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      mode_q <= fifo_mode_i;
      if (flush) begin
        ovr_q <= 1'b0;
        ack_q <= 1'b0;
      end else begin
        ovr_q <= ovr_set | (ovr_q & ~stat_rd_i);
        // head tags acknowledged by a status read until the head leaves
        if (f_pop)                     ack_q <= 1'b0;
        else if (stat_rd_i && !f_empty) ack_q <= 1'b1;
      end
    end
  end

  assign head_err    = (!f_empty && !ack_q) ? {f_head.brk, f_head.stop_bad, f_head.par_bad} : 3'b000;
  assign buf_data_o  = mode_q ? (f_empty ? '0 : f_head.data) : h_data;
  assign stat_o      = {(mode_q ? head_err : h_err), ovr_q, (mode_q ? !f_empty : h_valid)};
  assign fifo_full_o = mode_q && f_full;

  // R2
  ready_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_i && !flush) |=> stat_o[0]);

  // R4
  hold_ovr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_mode_i && !flush && rx_done_i && stat_o[0] && !buf_rd_i)
    |=> (stat_o[1] && buf_data_o == $past(rx_char_i)));

  // R5
  fifo_ovr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_mode_i && !flush && rx_done_i && fifo_full_o && !buf_rd_i)
    |=> (stat_o[1] && fifo_full_o && $stable(buf_data_o)));

  // R6
  ovr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !ovr_set) |=> !stat_o[1]);

  // R10
  flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> (stat_o == '0 && !fifo_full_o && buf_data_o == '0));

  // R1
  always_comb begin
    if (!rst_ni) reset_state_chk: assert (stat_o == '0 && !fifo_full_o);
  end
endmodule

// File: tb/uart_rx_line_status_bench.sv
module uart_rx_line_status_bench;
  localparam int DEPTH = 16;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       fifo_mode_i = 1'b0;
  logic       rx_done_i = 1'b0;
  logic [7:0] rx_char_i = '0;
  logic       rx_par_bad_i = 1'b0, rx_stop_bad_i = 1'b0, rx_brk_i = 1'b0;
  logic       buf_rd_i = 1'b0, stat_rd_i = 1'b0;
  logic [7:0] buf_data_o;
  logic [4:0] stat_o;
  logic       fifo_full_o;

  int total = 0;
  int bad   = 0;

  always #2 clk_i = ~clk_i;

  uart_rx_line_status #(.DEPTH(DEPTH)) u_uart_rx_line_status (
    .clk_i, .rst_ni, .fifo_mode_i, .rx_done_i, .rx_char_i, .rx_par_bad_i,
    .rx_stop_bad_i, .rx_brk_i, .buf_rd_i, .stat_rd_i, .buf_data_o, .stat_o, .fifo_full_o
  );

  // reference model
  logic [10:0] q[$];
  logic        m_mode = 1'b0;
  logic        h_v = 1'b0;
  logic [7:0]  h_d = '0;
  logic [2:0]  h_e = '0;
  logic        m_ovr = 1'b0;
  logic        m_ack = 1'b0;

  task automatic model_edge();
    logic pop, oset;
    if (fifo_mode_i != m_mode) begin
      m_mode = fifo_mode_i;
      q.delete();
      h_v = 1'b0; h_e = '0; m_ovr = 1'b0; m_ack = 1'b0;
      return;
    end
    if (m_mode) begin
      pop  = buf_rd_i && q.size() > 0;
      oset = rx_done_i && q.size() == DEPTH && !pop;
      if (pop) m_ack = 1'b0;
      else if (stat_rd_i && q.size() > 0) m_ack = 1'b1;
      if (pop) void'(q.pop_front());
      if (rx_done_i && !oset) q.push_back({rx_brk_i, rx_stop_bad_i, rx_par_bad_i, rx_char_i});
    end else begin
      oset = rx_done_i && h_v && !buf_rd_i;
      if (rx_done_i) begin h_v = 1'b1; h_d = rx_char_i; end
      else if (buf_rd_i) h_v = 1'b0;
    end
    h_e = (rx_done_i && !m_mode ? {rx_brk_i, rx_stop_bad_i, rx_par_bad_i} : 3'b000)
          | (h_e & {3{!stat_rd_i}});
    m_ovr = oset | (m_ovr & !stat_rd_i);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp,
                       input string req, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s [%s] act=%0h exp=%0h", req, what, tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    logic [7:0] e_d;
    logic [2:0] e_e;
    logic       e_r, e_f;
    if (m_mode) begin
      e_r = q.size() > 0;
      e_d = e_r ? q[0][7:0] : 8'h00;
      e_e = (e_r && !m_ack) ? q[0][10:8] : 3'b000;
      e_f = q.size() == DEPTH;
    end else begin
      e_r = h_v;
      e_d = h_v ? h_d : 8'h00;
      e_e = h_e;
      e_f = 1'b0;
    end
    check(tag, buf_data_o, e_d, "R3", "data");
    check(tag, stat_o[0], e_r, "R2", "ready");
    check(tag, stat_o[1], m_ovr, "R6", "overrun");
    check(tag, stat_o[4:2], e_e, m_mode ? "R8" : "R7", "errors");
    check(tag, fifo_full_o, e_f, "R5", "full");
  endtask

  task automatic step(input string tag, input logic dn, input logic [7:0] ch,
                      input logic [2:0] err, input logic brd, input logic srd);
    rx_done_i = dn; rx_char_i = ch;
    {rx_brk_i, rx_stop_bad_i, rx_par_bad_i} = err;
    buf_rd_i = brd; stat_rd_i = srd;
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
    compare(tag);
  endtask

  task automatic idle(input string tag);
    step(tag, 1'b0, 8'h00, 3'b000, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog all-R act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 in reset", {buf_data_o, stat_o, fifo_full_o}, 0, "R1", "outputs");
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare("R1 after reset");

    // single-buffer mode
    step("R2 first char", 1'b1, 8'h41, 3'b000, 1'b0, 1'b0);
    step("R4 overwrite", 1'b1, 8'h42, 3'b000, 1'b0, 1'b0);
    check("R4 new kept", buf_data_o, 8'h42, "R4", "data");
    check("R4 ovr set", stat_o[1], 1'b1, "R4", "overrun");
    step("R6 clear", 1'b0, 8'h00, 3'b000, 1'b0, 1'b1);
    step("R4 read+new", 1'b1, 8'h43, 3'b000, 1'b1, 1'b0);
    check("R4 no ovr", stat_o[1], 1'b0, "R4", "overrun");
    step("R6 set wins", 1'b1, 8'h44, 3'b000, 1'b0, 1'b1);
    check("R6 set wins", stat_o[1], 1'b1, "R6", "overrun");
    step("R7 parity char", 1'b1, 8'h45, 3'b001, 1'b1, 1'b0);
    step("R7 buf read", 1'b0, 8'h00, 3'b000, 1'b1, 1'b0);
    check("R7 sticky", stat_o[2], 1'b1, "R7", "parity");
    check("R2 ready low", stat_o[0], 1'b0, "R2", "ready");
    step("R11 empty read", 1'b0, 8'h00, 3'b000, 1'b1, 1'b0);
    check("R11 zero data", buf_data_o, 8'h00, "R11", "data");
    step("R7 stat read+set", 1'b1, 8'h46, 3'b110, 1'b0, 1'b1);
    check("R7 set wins", stat_o[4:2], 3'b110, "R7", "errors");
    idle("R7 idle");

    // mode change
    fifo_mode_i = 1'b1;
    step("R10 flush", 1'b1, 8'h47, 3'b000, 1'b0, 1'b0);
    check("R10 cleared", stat_o, 5'b0, "R10", "status");
    step("R8 e0", 1'b1, 8'h10, 3'b000, 1'b0, 1'b0);
    step("R8 e1", 1'b1, 8'h11, 3'b010, 1'b0, 1'b0);
    step("R8 e2", 1'b1, 8'h12, 3'b101, 1'b0, 1'b0);
    check("R8 clean head", stat_o[4:2], 3'b000, "R8", "errors");
    step("R3 pop", 1'b0, 8'h00, 3'b000, 1'b1, 1'b0);
    check("R8 head tag", stat_o[4:2], 3'b010, "R8", "errors");
    step("R9 hide", 1'b0, 8'h00, 3'b000, 1'b0, 1'b1);
    check("R9 hidden", stat_o[4:2], 3'b000, "R9", "errors");
    step("R9 next", 1'b0, 8'h00, 3'b000, 1'b1, 1'b0);
    check("R9 next head", stat_o[4:2], 3'b101, "R9", "errors");
    step("R3 drain", 1'b0, 8'h00, 3'b000, 1'b1, 1'b0);
    check("R2 drained", stat_o[0], 1'b0, "R2", "ready");
    step("R11 fifo empty read", 1'b0, 8'h00, 3'b000, 1'b1, 1'b0);

    for (int i = 0; i < DEPTH; i++) step("R5 fill", 1'b1, 8'(8'h80 + i), 3'b000, 1'b0, 1'b0);
    check("R5 full", fifo_full_o, 1'b1, "R5", "full");
    step("R5 drop", 1'b1, 8'hEE, 3'b111, 1'b0, 1'b0);
    check("R5 ovr", stat_o[1], 1'b1, "R5", "overrun");
    step("R5 read+push", 1'b1, 8'hEF, 3'b000, 1'b1, 1'b1);
    check("R5 accepted", fifo_full_o, 1'b1, "R5", "full");
    for (int i = 0; i < DEPTH; i++) step("R3 order", 1'b0, 8'h00, 3'b000, 1'b1, 1'b0);
    fifo_mode_i = 1'b0;
    step("R10 back", 1'b0, 8'h00, 3'b000, 1'b0, 1'b0);

    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 299) == 0) fifo_mode_i = ~fifo_mode_i;
      step("random", $urandom_range(0, 1) == 1, 8'($urandom),
           {$urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0},
           $urandom_range(0, 9) < 4, $urandom_range(0, 4) == 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule